// File: doc/BRIEF.md
# TMDS Test Pattern Generator

This block sits in front of the three data-channel serializers of a display transmitter. On every clock it picks the 10-bit character for each data channel from one of four sources: all zeros, the normal encoded words from upstream, a pseudo-random bit sequence, or a programmed rotating pattern of eight symbols. It also produces a 10-bit word for the clock channel, taken from a programmable 40-bit pattern that can rotate one symbol per cycle. Rotation is used when the link clock runs at a quarter of the character rate.

All settings are static control fields driven by a register block elsewhere. The PRBS engine offers four polynomials and three output widths. The shift engine holds each symbol for a programmable number of cycles. The clock-pattern engine copies its programmed value into a working register on a load pulse.

Each engine is a small named state machine:
- PRBS engine: `PR_HOLD` (disabled or idle width), `PR_SEED` (escape from an all-zero register) and `PR_STEP` (advance by the selected width).
- Shift engine: `SH_IDLE` and `SH_RUN`. `SH_IDLE` goes to `SH_RUN` when the enable rises, and `SH_RUN` goes back to `SH_IDLE`, clearing its counters, when the enable falls.
- Clock engine: `CK_HOLD`, `CK_LOAD` and `CK_ROTATE`.
- Output selector: decodes the select field into the modes `MODE_ZERO`, `MODE_DATA`, `MODE_PRBS` and `MODE_SHIFT`.

Top module: `tmds_pattern_gen`

## Requirements
- R1: After reset every output (`ch_out0..2`, `clk_out`) is zero, and all internal pattern state is zero.
- R2: `out_sel` picks the data-channel source. 3'b000 gives zeros, 3'b001 gives `ch_inN`, 3'b010 gives the PRBS word and 3'b100 gives the shift symbol. Every other code gives zeros. Each output word appears one clock after the inputs that produce it.
- R3: `prbs_poly` picks the recurrence, with b[n] = b[n-L] xor b[n-T]. Code 0 is L=11, T=9. Code 1 is L=15, T=14. Code 2 is L=7, T=6. Code 3 is L=31, T=28. The register shifts toward its MSB and takes the new bit in bit 0. Output bit 0 is the earliest bit produced in that cycle.
- R4: `prbs_width` sets the number of bits produced per cycle. Code 0 means idle: the output is zero and the register does not advance. Code 1 produces 8 bits in [7:0], code 2 produces 1 bit in [0], and code 3 produces 10 bits. Unused upper bits are zero. All three channels carry the same PRBS word.
- R5: With `prbs_en` low the PRBS word is zero and the register holds. It resumes from the same point when the enable returns.
- R6: If the low L bits of the register are all zero while the engine is enabled with a non-idle width, the register is loaded with all ones and the word for that cycle is zero.
- R7: Shift symbol k is `shift_pattern[10k+9:10k]`. While `shift_en` is high the symbols are presented in the order 0,1,...,7,0,... on all three channels. While it is low the symbol index and hold count are cleared and the word is zero.
- R8: With `shift_repeat` = R, each shift symbol is presented for R+1 consecutive cycles.
- R9: A cycle with `clk_pat_load` high copies `clk_pat` into the working register. `clk_out` then shows its bits [9:0], and the load takes priority over rotation.
- R10: With `clk_pat_rotate` high and no load, the working register rotates right by 10 bits each cycle, so the next `clk_out` is the previous bits [19:10]. With both inputs low the register holds.
- R11: `clk_out` does not depend on `out_sel` or on any data-channel setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_sel | input | 3 | Data-channel source select |
| prbs_en | input | 1 | PRBS engine enable |
| prbs_poly | input | 2 | PRBS polynomial code |
| prbs_width | input | 2 | PRBS bits per cycle code |
| shift_en | input | 1 | Shift pattern engine enable |
| shift_repeat | input | 3 | Extra cycles each shift symbol is held |
| shift_pattern | input | 80 | Eight 10-bit shift symbols, symbol 0 in bits 9:0 |
| clk_pat | input | 40 | Programmed clock-channel pattern |
| clk_pat_load | input | 1 | Copy `clk_pat` into the working register |
| clk_pat_rotate | input | 1 | Rotate the working clock pattern each cycle |
| ch_in0 | input | 10 | Normal encoded word, channel 0 |
| ch_in1 | input | 10 | Normal encoded word, channel 1 |
| ch_in2 | input | 10 | Normal encoded word, channel 2 |
| ch_out0 | output | 10 | Selected word, channel 0 |
| ch_out1 | output | 10 | Selected word, channel 1 |
| ch_out2 | output | 10 | Selected word, channel 2 |
| clk_out | output | 10 | Clock-channel word |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it. This holds for the data-channel word of each mode, the PRBS step or seed, the shift symbol and its hold count, and the clock-pattern load or rotation. The driver changes inputs on the falling edge. It advances a requirement-level model of the LFSR, shift index, hold count and clock working register by one step, and queues the four words expected after the next rising edge. The monitor takes one queued item 5 ns after each rising edge and compares all four outputs, so every check lands in the cycle in which the registered result is first visible.

// File: rtl/tmds_pg_pkg.sv
package tmds_pg_pkg;

    // Output source select codes (field decoded by the output selector)
    localparam logic [2:0] SEL_ZERO  = 3'b000;
    localparam logic [2:0] SEL_DATA  = 3'b001;
    localparam logic [2:0] SEL_PRBS  = 3'b010;
    localparam logic [2:0] SEL_SHIFT = 3'b100;

    // PRBS polynomial codes
    localparam logic [1:0] POLY_11 = 2'd0;
    localparam logic [1:0] POLY_15 = 2'd1;
    localparam logic [1:0] POLY_7  = 2'd2;
    localparam logic [1:0] POLY_31 = 2'd3;

    // PRBS width codes
    localparam logic [1:0] PW_IDLE = 2'd0;
    localparam logic [1:0] PW_BYTE = 2'd1;
    localparam logic [1:0] PW_BIT  = 2'd2;
    localparam logic [1:0] PW_FULL = 2'd3;

    typedef enum logic [1:0] {
        MODE_ZERO,
        MODE_DATA,
        MODE_PRBS,
        MODE_SHIFT
    } out_mode_e;

    typedef enum logic [1:0] {
        PR_HOLD,
        PR_SEED,
        PR_STEP
    } prbs_act_e;

    typedef enum logic {
        SH_IDLE,
        SH_RUN
    } shift_st_e;

    typedef enum logic [1:0] {
        CK_HOLD,
        CK_LOAD,
        CK_ROTATE
    } clk_act_e;

endpackage

// File: rtl/tmds_pg_prbs.sv
module tmds_pg_prbs
    import tmds_pg_pkg::*;
#(
    parameter int SYM_W  = 10,
    parameter int LFSR_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       poly,
    input  logic [1:0]       width,
    output logic [SYM_W-1:0] word
);

    localparam int IDX_W = $clog2(LFSR_W);

    logic [LFSR_W-1:0] lfsr;
    logic [LFSR_W-1:0] lfsr_nxt;
    logic [LFSR_W-1:0] len_mask;
    logic [LFSR_W-1:0] walk;
    logic [SYM_W-1:0]  walk_word;
    logic [IDX_W-1:0]  msb_i;
    logic [IDX_W-1:0]  tap_i;
    logic              fb;
    logic              low_zero;
    int                nbits;
    prbs_act_e         act;

    // Polynomial and width decode
    always_comb begin
        unique case (poly)
            POLY_11: begin msb_i = IDX_W'(10); tap_i = IDX_W'(8);  end
            POLY_15: begin msb_i = IDX_W'(14); tap_i = IDX_W'(13); end
            POLY_7:  begin msb_i = IDX_W'(6);  tap_i = IDX_W'(5);  end
            POLY_31: begin msb_i = IDX_W'(30); tap_i = IDX_W'(27); end
        endcase
        unique case (width)
            PW_IDLE: nbits = 0;
            PW_BYTE: nbits = 8;
            PW_BIT:  nbits = 1;
            PW_FULL: nbits = SYM_W;
        endcase
        len_mask = {LFSR_W{1'b1}} >> (LFSR_W - 1 - int'(msb_i));
        low_zero = ((lfsr & len_mask) == '0);
    end

    // Action select
    always_comb begin
        if (!en || width == PW_IDLE) begin
            act = PR_HOLD;
        end else if (low_zero) begin
            act = PR_SEED;
        end else begin
            act = PR_STEP;
        end
    end

    // Multi-bit advance: bit 0 of the word is the earliest bit produced
    always_comb begin
        walk      = lfsr;
        walk_word = '0;
        fb        = 1'b0;
        for (int i = 0; i < SYM_W; i++) begin
            if (i < nbits) begin
                fb           = walk[msb_i] ^ walk[tap_i];
                walk         = {walk[LFSR_W-2:0], fb};
                walk_word[i] = fb;
            end
        end
    end

    always_comb begin
        unique case (act)
            PR_HOLD: begin lfsr_nxt = lfsr;             word = '0;        end
            PR_SEED: begin lfsr_nxt = {LFSR_W{1'b1}};   word = '0;        end
            PR_STEP: begin lfsr_nxt = walk;             word = walk_word; end
            default: begin lfsr_nxt = lfsr;             word = '0;        end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr <= '0;
        end else begin
            lfsr <= lfsr_nxt;
        end
    end

    // R5: a disabled engine keeps its register
    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(lfsr));

    // R6: an enabled, non-idle engine never stays locked at zero
    a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (en && width != PW_IDLE && low_zero) |=> ((lfsr & len_mask) != '0));

endmodule

// File: rtl/tmds_pg_shift.sv
module tmds_pg_shift
    import tmds_pg_pkg::*;
#(
    parameter int SYM_W = 10,
    parameter int NSYM  = 8,
    parameter int RPT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic [RPT_W-1:0]      rep_cfg,
    input  logic [SYM_W*NSYM-1:0] pattern,
    output logic [SYM_W-1:0]      word
);

    localparam int IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSYM - 1);

    shift_st_e        st;
    shift_st_e        st_nxt;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nxt;
    logic [RPT_W-1:0] cnt;
    logic [RPT_W-1:0] cnt_nxt;

    // Named state transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            SH_IDLE: if (en)  st_nxt = SH_RUN;
            SH_RUN:  if (!en) st_nxt = SH_IDLE;
            default: st_nxt = SH_IDLE;
        endcase
    end

    // Symbol index and hold counter
    always_comb begin
        idx_nxt = idx;
        cnt_nxt = cnt;
        if (!en) begin
            idx_nxt = '0;
            cnt_nxt = '0;
        end else if (cnt == rep_cfg) begin
            cnt_nxt = '0;
            idx_nxt = (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end else begin
            cnt_nxt = cnt + 1'b1;
        end
    end

    always_comb begin
        word = en ? pattern[int'(idx)*SYM_W +: SYM_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SH_IDLE;
            idx <= '0;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            idx <= idx_nxt;
            cnt <= cnt_nxt;
        end
    end

    // R8: symbol is held until the counter reaches the repeat value
    a_r8_hold_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt != rep_cfg) |=> $stable(idx));

    // R7: the last symbol wraps to the first
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == rep_cfg && idx == LAST_IDX) |=> (idx == '0));

    // R7: disabling clears the sequence position
    a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (idx == '0 && cnt == '0 && st == SH_IDLE));

endmodule

// File: rtl/tmds_pg_clkpat.sv
module tmds_pg_clkpat
    import tmds_pg_pkg::*;
#(
    parameter int SYM_W = 10,
    parameter int NSYM  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  rot_en,
    input  logic [SYM_W*NSYM-1:0] pattern,
    output logic [SYM_W-1:0]      word
);

    localparam int PAT_W = SYM_W * NSYM;

    logic [PAT_W-1:0] work;
    logic [PAT_W-1:0] work_nxt;
    clk_act_e         act;

    always_comb begin
        if (load) begin
            act = CK_LOAD;
        end else if (rot_en) begin
            act = CK_ROTATE;
        end else begin
            act = CK_HOLD;
        end
    end

    always_comb begin
        unique case (act)
            CK_LOAD:   work_nxt = pattern;
            CK_ROTATE: work_nxt = {work[SYM_W-1:0], work[PAT_W-1:SYM_W]};
            CK_HOLD:   work_nxt = work;
            default:   work_nxt = work;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work <= '0;
        end else begin
            work <= work_nxt;
        end
    end

    assign word = work[SYM_W-1:0];

    // R9: a load copies the programmed pattern
    a_r9_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (work == $past(pattern)));

    // R10: without load or rotate the register holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !rot_en) |=> $stable(work));

    // R10: rotation brings the second symbol to the output
    a_r10_rotate_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rot_en) |=> (word == $past(work[2*SYM_W-1:SYM_W])));

endmodule

// File: rtl/tmds_pattern_gen.sv
module tmds_pattern_gen
    import tmds_pg_pkg::*;
#(
    parameter int SYM_W      = 10,
    parameter int SHIFT_SYMS = 8,
    parameter int CLK_SYMS   = 4,
    parameter int RPT_W      = 3,
    parameter int LFSR_W     = 31
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2:0]                  out_sel,
    input  logic                        prbs_en,
    input  logic [1:0]                  prbs_poly,
    input  logic [1:0]                  prbs_width,
    input  logic                        shift_en,
    input  logic [RPT_W-1:0]            shift_repeat,
    input  logic [SYM_W*SHIFT_SYMS-1:0] shift_pattern,
    input  logic [SYM_W*CLK_SYMS-1:0]   clk_pat,
    input  logic                        clk_pat_load,
    input  logic                        clk_pat_rotate,
    input  logic [SYM_W-1:0]            ch_in0,
    input  logic [SYM_W-1:0]            ch_in1,
    input  logic [SYM_W-1:0]            ch_in2,
    output logic [SYM_W-1:0]            ch_out0,
    output logic [SYM_W-1:0]            ch_out1,
    output logic [SYM_W-1:0]            ch_out2,
    output logic [SYM_W-1:0]            clk_out
);

    localparam int NCH = 3;

    out_mode_e        mode;
    logic [SYM_W-1:0] prbs_word;
    logic [SYM_W-1:0] shift_word;
    logic [SYM_W-1:0] din  [NCH];
    logic [SYM_W-1:0] ch_q [NCH];

    assign din[0] = ch_in0;
    assign din[1] = ch_in1;
    assign din[2] = ch_in2;

    tmds_pg_prbs #(
        .SYM_W  (SYM_W),
        .LFSR_W (LFSR_W)
    ) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (prbs_en),
        .poly  (prbs_poly),
        .width (prbs_width),
        .word  (prbs_word)
    );

    tmds_pg_shift #(
        .SYM_W (SYM_W),
        .NSYM  (SHIFT_SYMS),
        .RPT_W (RPT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (shift_en),
        .rep_cfg (shift_repeat),
        .pattern (shift_pattern),
        .word    (shift_word)
    );

    tmds_pg_clkpat #(
        .SYM_W (SYM_W),
        .NSYM  (CLK_SYMS)
    ) u_clkpat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (clk_pat_load),
        .rot_en  (clk_pat_rotate),
        .pattern (clk_pat),
        .word    (clk_out)
    );

    // Source decode: unlisted codes fall back to zero output
    always_comb begin
        unique case (out_sel)
            SEL_ZERO:  mode = MODE_ZERO;
            SEL_DATA:  mode = MODE_DATA;
            SEL_PRBS:  mode = MODE_PRBS;
            SEL_SHIFT: mode = MODE_SHIFT;
            default:   mode = MODE_ZERO;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_q[c] <= '0;
            end else begin
                unique case (mode)
                    MODE_ZERO:  ch_q[c] <= '0;
                    MODE_DATA:  ch_q[c] <= din[c];
                    MODE_PRBS:  ch_q[c] <= prbs_word;
                    MODE_SHIFT: ch_q[c] <= shift_word;
                    default:    ch_q[c] <= '0;
                endcase
            end
        end
    end

    assign ch_out0 = ch_q[0];
    assign ch_out1 = ch_q[1];
    assign ch_out2 = ch_q[2];

    // R2: unlisted and zero select codes give a zero word
    a_r2_zero_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel != SEL_DATA && out_sel != SEL_PRBS && out_sel != SEL_SHIFT)
        |=> (ch_out0 == '0 && ch_out1 == '0 && ch_out2 == '0));

    // R2: data mode forwards each channel one cycle later
    a_r2_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == SEL_DATA) |=> (ch_out1 == $past(ch_in1)));

    // R4: one-bit PRBS leaves the upper bits at zero
    a_r4_bit_width: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == SEL_PRBS && prbs_width == PW_BIT) |=> (ch_out0[SYM_W-1:1] == '0));

    // R7: shift mode drives one symbol onto all channels
    a_r7_same_symbol: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == SEL_SHIFT) |=> (ch_out0 == ch_out1 && ch_out1 == ch_out2));

endmodule

// File: tb/tmds_pattern_gen_test.sv
module tmds_pattern_gen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  out_sel;
    logic        prbs_en;
    logic [1:0]  prbs_poly;
    logic [1:0]  prbs_width;
    logic        shift_en;
    logic [2:0]  shift_repeat;
    logic [79:0] shift_pattern;
    logic [39:0] clk_pat;
    logic        clk_pat_load;
    logic        clk_pat_rotate;
    logic [9:0]  ch_in0, ch_in1, ch_in2;
    logic [9:0]  ch_out0, ch_out1, ch_out2, clk_out;

    always #10 clk = ~clk;

    tmds_pattern_gen uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .out_sel        (out_sel),
        .prbs_en        (prbs_en),
        .prbs_poly      (prbs_poly),
        .prbs_width     (prbs_width),
        .shift_en       (shift_en),
        .shift_repeat   (shift_repeat),
        .shift_pattern  (shift_pattern),
        .clk_pat        (clk_pat),
        .clk_pat_load   (clk_pat_load),
        .clk_pat_rotate (clk_pat_rotate),
        .ch_in0         (ch_in0),
        .ch_in1         (ch_in1),
        .ch_in2         (ch_in2),
        .ch_out0        (ch_out0),
        .ch_out1        (ch_out1),
        .ch_out2        (ch_out2),
        .clk_out        (clk_out)
    );

    typedef struct packed {
        logic [9:0] c0;
        logic [9:0] c1;
        logic [9:0] c2;
        logic [9:0] ck;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    // Requirement-level model state
    logic [30:0] m_lfsr = '0;
    int          m_idx  = 0;
    int          m_cnt  = 0;
    logic [39:0] m_work = '0;

    task automatic model_prbs(output logic [9:0] w);
        int len, tap, nb_cnt;
        logic [30:0] mask;
        logic b;
        w = '0;
        case (prbs_poly)
            2'd0:    begin len = 11; tap = 9;  end
            2'd1:    begin len = 15; tap = 14; end
            2'd2:    begin len = 7;  tap = 6;  end
            default: begin len = 31; tap = 28; end
        endcase
        case (prbs_width)
            2'd1:    nb_cnt = 8;
            2'd2:    nb_cnt = 1;
            2'd3:    nb_cnt = 10;
            default: nb_cnt = 0;
        endcase
        mask = 31'h7FFF_FFFF >> (31 - len);
        if (!prbs_en || nb_cnt == 0) begin
            w = '0;
        end else if ((m_lfsr & mask) == '0) begin
            m_lfsr = 31'h7FFF_FFFF;
        end else begin
            for (int i = 0; i < nb_cnt; i++) begin
                b      = m_lfsr[len-1] ^ m_lfsr[tap-1];
                m_lfsr = {m_lfsr[29:0], b};
                w[i]   = b;
            end
        end
    endtask

    task automatic model_shift(output logic [9:0] w);
        if (!shift_en) begin
            m_idx = 0;
            m_cnt = 0;
            w     = '0;
        end else begin
            w = shift_pattern[m_idx*10 +: 10];
            if (m_cnt == int'(shift_repeat)) begin
                m_cnt = 0;
                m_idx = (m_idx + 1) % 8;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    // Driver: model one clock of the inputs now applied, queue the result
    task automatic tick(input string tag);
        logic [9:0] pw, sw;
        exp_t e;
        model_prbs(pw);
        model_shift(sw);
        if (clk_pat_load) m_work = clk_pat;
        else if (clk_pat_rotate) m_work = {m_work[9:0], m_work[39:10]};
        case (out_sel)
            3'b001:  begin e.c0 = ch_in0; e.c1 = ch_in1; e.c2 = ch_in2; end
            3'b010:  begin e.c0 = pw; e.c1 = pw; e.c2 = pw; end
            3'b100:  begin e.c0 = sw; e.c1 = sw; e.c2 = sw; end
            default: begin e.c0 = '0; e.c1 = '0; e.c2 = '0; end
        endcase
        e.ck = m_work[9:0];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare one queued item after each rising edge
    always @(posedge clk) begin
        exp_t  e;
        string t;
        #5;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (ch_out0 !== e.c0 || ch_out1 !== e.c1 || ch_out2 !== e.c2 || clk_out !== e.ck) begin
                fails++;
                $display("FAIL %s: got %h %h %h clk %h, expected %h %h %h clk %h",
                         t, ch_out0, ch_out1, ch_out2, clk_out, e.c0, e.c1, e.c2, e.ck);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        out_sel = '0; prbs_en = 0; prbs_poly = '0; prbs_width = '0;
        shift_en = 0; shift_repeat = '0; shift_pattern = '0;
        clk_pat = '0; clk_pat_load = 0; clk_pat_rotate = 0;
        ch_in0 = '0; ch_in1 = '0; ch_in2 = '0;
        for (int k = 0; k < 8; k++) shift_pattern[k*10 +: 10] = 10'(10'h2B5 ^ (k * 77));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        ch_in0 = 10'h155; ch_in1 = 10'h2AA; ch_in2 = 10'h0F0;
        tick("R1 reset");

        // R2: normal data pass-through
        out_sel = 3'b001;
        for (int k = 0; k < 4; k++) begin
            ch_in0 = 10'(k * 131 + 7); ch_in1 = 10'(k * 59 + 300); ch_in2 = 10'(1023 - k * 17);
            tick("R2 data");
        end
        // R2: unlisted codes give zero
        out_sel = 3'b011; tick("R2 code 011");
        out_sel = 3'b110; tick("R2 code 110");
        out_sel = 3'b111; tick("R2 code 111");

        // R6 then R3: seed and run each polynomial at full width
        out_sel = 3'b010; prbs_en = 1; prbs_width = 2'd3; prbs_poly = 2'd0;
        tick("R6 seed");
        for (int k = 0; k < 6; k++) tick("R3 poly 11");
        prbs_poly = 2'd1; for (int k = 0; k < 5; k++) tick("R3 poly 15");
        prbs_poly = 2'd2; for (int k = 0; k < 5; k++) tick("R3 poly 7");
        prbs_poly = 2'd3; for (int k = 0; k < 5; k++) tick("R3 poly 31");

        // R4: widths
        prbs_poly = 2'd0;
        prbs_width = 2'd1; for (int k = 0; k < 5; k++) tick("R4 byte width");
        prbs_width = 2'd2; for (int k = 0; k < 12; k++) tick("R4 bit width");
        prbs_width = 2'd0; for (int k = 0; k < 3; k++) tick("R4 idle width");
        prbs_width = 2'd3; for (int k = 0; k < 3; k++) tick("R4 resume after idle");

        // R5: disable holds, then resume
        prbs_en = 0; for (int k = 0; k < 3; k++) tick("R5 disabled");
        prbs_en = 1; for (int k = 0; k < 3; k++) tick("R5 resumed");

        // R7 and R8: shift pattern
        out_sel = 3'b100; shift_en = 1; shift_repeat = 3'd0;
        for (int k = 0; k < 18; k++) tick("R7 shift order");
        shift_en = 0; for (int k = 0; k < 2; k++) tick("R7 shift off");
        shift_en = 1; shift_repeat = 3'd3;
        for (int k = 0; k < 20; k++) tick("R8 repeat 3");
        shift_repeat = 3'd7;
        for (int k = 0; k < 18; k++) tick("R8 repeat 7");

        // R9 and R10: clock pattern
        clk_pat = 40'hA5_1234_5C3F;
        clk_pat_load = 1; tick("R9 load");
        clk_pat_load = 0;
        for (int k = 0; k < 3; k++) tick("R10 hold");
        clk_pat_rotate = 1;
        for (int k = 0; k < 6; k++) tick("R10 rotate");
        clk_pat = 40'h3F_00FF_C00C;
        clk_pat_load = 1; tick("R9 load over rotate");
        clk_pat_load = 0;
        // R11: change data source while the clock pattern rotates
        out_sel = 3'b001; tick("R11 clk vs data");
        out_sel = 3'b000; tick("R11 clk vs zero");
        out_sel = 3'b010; tick("R11 clk vs prbs");
        out_sel = 3'b101; tick("R11 clk vs bad code");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule